// File: doc/BRIEF.md
# ADC Power-Down and Warm-Up Sequencer

This block sits on the digital side of a stereo audio converter and decides when sample words may leave it. An active-low power-down input holds the downstream decimation filter in reset and forces both channel outputs to zero. When power-down is released, the block waits for the first active edge of the frame clock and counts whole frame periods from there. Until that count finishes, both outputs stay at zero. After it, the left and right sample words pass through to the output registers unchanged.

The warm-up length depends on the clocking role: a shorter count when the converter drives the frame clock, and one frame more when it follows an external frame clock. A second mode input selects whether the frame clock's rising or falling edge marks a frame boundary. The frame clock is brought into the system clock domain through a synchronizer before its edges are detected. The power-down input is taken to be synchronous to the system clock.

Top module: `adc_pwr_seq`

## Requirements
- R1: While `pwrdn_n` is sampled low, `filt_rst` is high from the next clock edge on, `init_done` is low and both channel outputs are zero. After `rst_n`, `filt_rst` is high and `init_done`, `out_valid` and `filt_rst_pulse` are low.
- R2: A high-to-low transition of `pwrdn_n` produces `filt_rst_pulse` high for exactly one cycle. Holding `pwrdn_n` low produces no further pulse.
- R3: The active frame edge is the rising edge of `frame_clk` when `frame_fall_mode` is 0 and the falling edge when it is 1. The other edge does not advance the warm-up count.
- R4: With `is_slave` = 0, warm-up ends on the 517th active frame edge after release, which means the first active edge plus 516 frame periods. A `frame_clk` transition set up before system clock edge k makes `init_done` high after edge k+3, and not before.
- R5: With `is_slave` = 1, warm-up ends on the 518th active frame edge after release, which means the first active edge plus 517 frame periods, with the same latency as R4.
- R6: While `init_done` is low, `out_left` and `out_right` are all zero, whatever is presented at the inputs.
- R7: While `init_done` is high, `out_left` and `out_right` equal `in_left` and `in_right` as sampled at the previous clock edge. `init_done` stays high until `pwrdn_n` is sampled low.
- R8: `out_valid` equals `in_valid` delayed by one clock in every phase: power-down, warm-up and running.
- R9: `pwrdn_n` going low at any point clears the warm-up count. After the next release, the full count of R4/R5 is needed again before `init_done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Frame (word-select) clock, asynchronous to `clk` |
| pwrdn_n | input | 1 | Active-low power-down, synchronous to `clk` |
| is_slave | input | 1 | 1 = follower clocking role (longer warm-up) |
| frame_fall_mode | input | 1 | 1 = falling frame edge is active |
| in_left | input | 24 | Left channel sample word |
| in_right | input | 24 | Right channel sample word |
| in_valid | input | 1 | Sample pair strobe |
| out_left | output | 24 | Gated left word |
| out_right | output | 24 | Gated right word |
| out_valid | output | 1 | Registered copy of `in_valid` |
| init_done | output | 1 | Warm-up finished, data unmuted |
| filt_rst | output | 1 | Filter reset, held while powered down |
| filt_rst_pulse | output | 1 | One-cycle pulse on entry to power-down |

## Verification
The data path and strobe respond one clock after their inputs, so the bench samples every output at the falling clock edge after the rising edge that follows the stimulus. It compares the sampled values with the inputs it drove one cycle earlier. `filt_rst`, `filt_rst_pulse` and the clearing of `init_done` follow `pwrdn_n` with the same one-cycle delay. A frame clock edge reaches `init_done` three rising clock edges after it is applied: two synchronizer stages, the state register and the flag register. The bench therefore checks `init_done` two and three cycles after the final counted edge, and again five cycles after the edge before it, so that a count that is one frame short or uses the wrong polarity lands on a checked cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_PD    = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2,
        ST_RUN   = 2'd3
    } seq_state_e;

    function automatic int unsigned warmup_len(input logic slave,
                                               input int unsigned master_n,
                                               input int unsigned slave_n);
        return slave ? slave_n : master_n;
    endfunction

endpackage

// File: rtl/fclk_edge.sv
module fclk_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_clk,
    input  logic fall_sel,
    output logic edge_p
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_regs_t;

    edge_regs_t r_d, r_q;
    logic       lvl;

    assign lvl = r_q.sync[LAST];

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[SYNC_STAGES-2:0], frame_clk};
        r_d.prev = lvl;
        if (fall_sel) begin
            edge_p = r_q.prev & ~lvl;
        end else begin
            edge_p = ~r_q.prev & lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/warmup_ctr.sv
module warmup_ctr #(
    parameter int unsigned MASTER_FRAMES = 516,
    parameter int unsigned SLAVE_FRAMES  = 517,
    parameter int          CNT_W         = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic is_slave,
    output logic last
);
    import adc_seq_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_regs_t;

    ctr_regs_t        r_d, r_q;
    logic [CNT_W-1:0] limit_m1;

    always_comb begin
        limit_m1 = CNT_W'(warmup_len(is_slave, MASTER_FRAMES, SLAVE_FRAMES) - 1);
        last     = (r_q.cnt == limit_m1);
        r_d      = r_q;
        if (clear) begin
            r_d.cnt = '0;
        end else if (tick && !last) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/out_gate.sv
module out_gate #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unmute,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic              in_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              out_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] left;
        logic [DATA_W-1:0] right;
        logic              vld;
    } gate_regs_t;

    gate_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.vld = in_valid;
        if (unmute) begin
            r_d.left  = in_left;
            r_d.right = in_right;
        end else begin
            r_d.left  = '0;
            r_d.right = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_left  = r_q.left;
    assign out_right = r_q.right;
    assign out_valid = r_q.vld;
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
    parameter int          DATA_W        = 24,
    parameter int unsigned MASTER_FRAMES = 516,
    parameter int unsigned SLAVE_FRAMES  = 517,
    parameter int          SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_clk,
    input  logic              pwrdn_n,
    input  logic              is_slave,
    input  logic              frame_fall_mode,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic              in_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              out_valid,
    output logic              init_done,
    output logic              filt_rst,
    output logic              filt_rst_pulse
);
    import adc_seq_pkg::*;

    localparam int unsigned MAX_FRAMES = (SLAVE_FRAMES > MASTER_FRAMES) ? SLAVE_FRAMES : MASTER_FRAMES;
    localparam int          CNT_W      = $clog2(MAX_FRAMES + 1);

    typedef struct packed {
        seq_state_e st;
        logic       done;
        logic       frst;
        logic       fpulse;
        logic       pd_prev;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      frame_edge;
    logic      cnt_last;
    logic      cnt_clear;
    logic      cnt_tick;
    logic      unmute;

    fclk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_clk(frame_clk),
        .fall_sel (frame_fall_mode),
        .edge_p   (frame_edge)
    );

    warmup_ctr #(
        .MASTER_FRAMES(MASTER_FRAMES),
        .SLAVE_FRAMES (SLAVE_FRAMES),
        .CNT_W        (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .tick    (cnt_tick),
        .is_slave(is_slave),
        .last    (cnt_last)
    );

    always_comb begin
        r_d       = r_q;
        unmute    = pwrdn_n && (r_q.st == ST_RUN);
        cnt_clear = !pwrdn_n || (r_q.st != ST_COUNT);
        cnt_tick  = frame_edge && (r_q.st == ST_COUNT);

        r_d.done    = unmute;
        r_d.frst    = !pwrdn_n;
        r_d.fpulse  = !pwrdn_n && r_q.pd_prev;
        r_d.pd_prev = pwrdn_n;

        if (!pwrdn_n) begin
            r_d.st = ST_PD;
        end else begin
            unique case (r_q.st)
                ST_PD:    r_d.st = ST_ARM;
                ST_ARM:   if (frame_edge) r_d.st = ST_COUNT;
                ST_COUNT: if (frame_edge && cnt_last) r_d.st = ST_RUN;
                ST_RUN:   r_d.st = ST_RUN;
                default:  r_d.st = ST_PD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_PD;
            r_q.done    <= 1'b0;
            r_q.frst    <= 1'b1;
            r_q.fpulse  <= 1'b0;
            r_q.pd_prev <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    out_gate #(.DATA_W(DATA_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .unmute   (unmute),
        .in_left  (in_left),
        .in_right (in_right),
        .in_valid (in_valid),
        .out_left (out_left),
        .out_right(out_right),
        .out_valid(out_valid)
    );

    assign init_done      = r_q.done;
    assign filt_rst       = r_q.frst;
    assign filt_rst_pulse = r_q.fpulse;
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwrdn_n,
    input logic [DATA_W-1:0] in_left,
    input logic [DATA_W-1:0] in_right,
    input logic              in_valid,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right,
    input logic              out_valid,
    input logic              init_done,
    input logic              filt_rst,
    input logic              filt_rst_pulse
);
    p_filt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_n |=> filt_rst);

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        filt_rst_pulse |=> !filt_rst_pulse);

    p_pulse_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwrdn_n) |=> filt_rst_pulse);

    p_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (out_left == '0 && out_right == '0));

    p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && $past(rst_n)) |-> (out_left == $past(in_left) && out_right == $past(in_right)));

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && pwrdn_n) |=> init_done);

    p_valid_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_n |=> (!init_done ##1 !init_done));
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwrdn_n       (pwrdn_n),
    .in_left       (in_left),
    .in_right      (in_right),
    .in_valid      (in_valid),
    .out_left      (out_left),
    .out_right     (out_right),
    .out_valid     (out_valid),
    .init_done     (init_done),
    .filt_rst      (filt_rst),
    .filt_rst_pulse(filt_rst_pulse)
);

// File: tb/sim_adc_pwr_seq.sv
module sim_adc_pwr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_FRAME = 4;
    localparam int N_MASTER   = 516;
    localparam int N_SLAVE    = 517;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_clk = 1'b0;
    logic        pwrdn_n = 1'b0;
    logic        is_slave = 1'b0;
    logic        frame_fall_mode = 1'b0;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic        in_valid = 1'b0;
    logic [23:0] out_left, out_right;
    logic        out_valid, init_done, filt_rst, filt_rst_pulse;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_pwr_seq u0 (
        .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .pwrdn_n(pwrdn_n),
        .is_slave(is_slave), .frame_fall_mode(frame_fall_mode),
        .in_left(in_left), .in_right(in_right), .in_valid(in_valid),
        .out_left(out_left), .out_right(out_right), .out_valid(out_valid),
        .init_done(init_done), .filt_rst(filt_rst), .filt_rst_pulse(filt_rst_pulse)
    );

    function automatic logic [23:0] exp_word(input logic done, input logic [23:0] w);
        return done ? w : 24'd0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        logic        sv;
        logic [23:0] sl, sr;
        sv = in_valid; sl = in_left; sr = in_right;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == sv, "R8", {31'd0, out_valid}, {31'd0, sv});
        chk(out_left == exp_word(init_done, sl), init_done ? "R7" : "R6", {8'd0, out_left}, {8'd0, exp_word(init_done, sl)});
        chk(out_right == exp_word(init_done, sr), init_done ? "R7" : "R6", {8'd0, out_right}, {8'd0, exp_word(init_done, sr)});
        in_valid = 1'($urandom % 2);
        in_left  = 24'($urandom);
        in_right = 24'($urandom);
    endtask

    task automatic frames(input int n, input int extra, input bit fallm, input string tag);
        for (int f = 1; f <= n + 1 + extra; f++) begin
            frame_clk = fallm ? 1'b0 : 1'b1;
            for (int c = 0; c < 2*HALF_FRAME; c++) begin
                if (c == HALF_FRAME) frame_clk = fallm ? 1'b1 : 1'b0;
                cyc();
                if (f == n && c == 5)
                    chk(init_done == 1'b0, tag, {31'd0, init_done}, 32'd0);
                if (f == n + 1 && c == 2)
                    chk(init_done == 1'b0, tag, {31'd0, init_done}, 32'd0);
                if (f == n + 1 && c == 3)
                    chk(init_done == 1'b1, fallm ? "R3" : tag, {31'd0, init_done}, 32'd1);
                if (f > n + 1 && c == 7)
                    chk(init_done == 1'b1, "R7", {31'd0, init_done}, 32'd1);
            end
        end
    endtask

    task automatic enter_pd();
        pwrdn_n = 1'b0;
        cyc();
        chk(filt_rst_pulse == 1'b1, "R2", {31'd0, filt_rst_pulse}, 32'd1);
        chk(filt_rst == 1'b1, "R1", {31'd0, filt_rst}, 32'd1);
        chk(init_done == 1'b0, "R9", {31'd0, init_done}, 32'd0);
        cyc();
        chk(filt_rst_pulse == 1'b0, "R2", {31'd0, filt_rst_pulse}, 32'd0);
    endtask

    task automatic scenario(input bit slave, input bit fallm, input int extra);
        int n;
        n = slave ? N_SLAVE : N_MASTER;
        is_slave = slave;
        frame_fall_mode = fallm;
        frame_clk = fallm ? 1'b1 : 1'b0;
        for (int i = 0; i < 4; i++) begin
            cyc();
            chk(filt_rst == 1'b1 && init_done == 1'b0, "R1", {30'd0, filt_rst, init_done}, 32'd2);
        end
        pwrdn_n = 1'b1;
        repeat (3) cyc();
        frames(n, extra, fallm, slave ? "R5" : "R4");
        enter_pd();
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        chk(init_done == 1'b0 && out_valid == 1'b0 && filt_rst_pulse == 1'b0, "R1",
            {29'd0, init_done, out_valid, filt_rst_pulse}, 32'd0);
        chk(filt_rst == 1'b1, "R1", {31'd0, filt_rst}, 32'd1);
        rst_n = 1'b1;
        repeat (3) cyc();
        chk(filt_rst_pulse == 1'b0, "R2", {31'd0, filt_rst_pulse}, 32'd0);

        scenario(1'b0, 1'b0, 3);
        scenario(1'b1, 1'b0, 2);
        scenario(1'b0, 1'b1, 2);
        scenario(1'b1, 1'b1, 1 + int'($urandom % 4));

        // R9: abort mid warm-up, then a full count is required again
        is_slave = 1'b0;
        frame_fall_mode = 1'b0;
        frame_clk = 1'b0;
        repeat (4) cyc();
        pwrdn_n = 1'b1;
        repeat (3) cyc();
        for (int f = 0; f < 300; f++) begin
            frame_clk = 1'b1;
            repeat (HALF_FRAME) cyc();
            frame_clk = 1'b0;
            repeat (HALF_FRAME) cyc();
        end
        chk(init_done == 1'b0, "R9", {31'd0, init_done}, 32'd0);
        enter_pd();
        pwrdn_n = 1'b1;
        repeat (3) cyc();
        frames(N_MASTER, 2, 1'b0, "R9");
        enter_pd();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule